// File: doc/BRIEF.md
# Integer status and condition flag unit

This block keeps the integer exception register of a 32-bit fixed-point datapath and writes condition field 0 of the condition register. Every cycle the execute stage may present one completed operation: its class, the overflow-enable flag, a record flag, the ALU result and the side information the ALU produced (carry out of the top bit and of the bit below it, a wide-result overflow indication, and the sign and lost-ones indications of an algebraic right shift). The block decides from the class which of the carry, overflow and sticky summary-overflow flags change, and how.

The exception register is read as one 32-bit word. The top three bits are the flags, the low seven bits are a byte count for indexed string transfers, and everything between always reads zero. A move of a data word into the register overwrites flags and count literally. A move of the flags into condition field 0 copies them out and clears them in the same cycle.

All state changes on one rising clock edge and only while `in_valid` is high. The pins are plain control and status signals: the block accepts an operation in every cycle, so it applies no back-pressure and has no ready output.

Top module: `int_flag_unit`

## Requirements
- R1: `xer_o` bit 31 is summary overflow, bit 30 overflow, bit 29 carry, bits 6..0 the byte count, and bits 28..7 always read zero; the byte count changes only on a move-to (op 7), taking `mt_data[6:0]`.
- R2: For op 1 (add/subtract-from/negate) or op 2 (carrying/extended forms) with `oe` high, overflow becomes `carry_top ^ carry_next`; with `oe` low these ops leave overflow unchanged.
- R3: For op 3 (multiply low) or op 4 (divide) with `oe` high, overflow becomes `wide_ovf`; with `oe` low overflow is unchanged.
- R4: Summary overflow becomes set in any cycle in which an op other than 7 or 8 sets overflow, and otherwise keeps its value until op 7 or op 8 is accepted.
- R5: Op 7 (move-to) loads summary overflow, overflow and carry from `mt_data[31]`, `mt_data[30]`, `mt_data[29]` literally, so a word with 0 and 1 in bits 31 and 30 leaves summary overflow clear and overflow set.
- R6: Op 2 sets carry to `carry_top`, whatever the value of `oe`.
- R7: Op 5 (shift right algebraic) sets carry to 1 only when `sra_neg` and `sra_lost` are both high, and clears it otherwise.
- R8: Op 6 (compare) and op 0 (no flag effect) leave all three flags unchanged, whatever `oe` and the carry inputs are.
- R9: When `rec` is high on an accepted op other than 8, `cr0_o` becomes {LT, GT, EQ, SO} in bits 3..0: LT = `result[31]`, GT = result positive and nonzero, EQ = result zero, SO = summary overflow after this op's update. Without `rec` `cr0_o` holds.
- R10: Op 8 (move flags to condition field) writes `cr0_o` = {SO, OV, CA, 0} as they were before the op, and clears all three flags the same cycle; the byte count is kept.
- R11: When `in_valid` is low, no output changes.
- R12: Reset (`rst_n` low) clears `xer_o` and `cr0_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operation in this cycle |
| op | input | 4 | Operation class, encoded as in the requirements |
| oe | input | 1 | Overflow-enable form |
| rec | input | 1 | Record the result into condition field 0 |
| result | input | 32 | ALU result |
| carry_top | input | 1 | Carry out of the most significant bit |
| carry_next | input | 1 | Carry out of the bit below the most significant |
| wide_ovf | input | 1 | Multiply/divide result does not fit in 32 bits |
| sra_neg | input | 1 | Shift operand is negative |
| sra_lost | input | 1 | At least one 1 bit was shifted out |
| mt_data | input | 32 | Data word for the move-to operation |
| xer_o | output | 32 | Integer exception register |
| cr0_o | output | 4 | Condition field 0, LT in bit 3 down to SO in bit 0 |

## Verification
The operation classes are driven in a chain where each flag is first set, then hit by classes that must leave it alone, so a class that wrongly touches a flag shows up as a changed value in the next step. Overflow-enabled and plain forms of the same class are paired to separate the enable rule from the arithmetic rule, and the shift is tried with each combination of sign and lost ones. Results that are negative, positive and zero are recorded while summary overflow is both set and clear, which separates the post-update copy from the pre-update one. The move-to word with summary overflow clear and overflow set, and a move to the condition field straight after flags were set, cover the literal and copy-then-clear paths.

// File: rtl/int_flag_pkg.sv
package int_flag_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_ADDSUB  = 4'd1,
    OP_CARRY   = 4'd2,
    OP_MULLO   = 4'd3,
    OP_DIVW    = 4'd4,
    OP_SRAW    = 4'd5,
    OP_CMP     = 4'd6,
    OP_MOVE_TO = 4'd7,
    OP_MOVE_CR = 4'd8
  } flag_op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } flags_t;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/int_flag_next.sv
module int_flag_next
  import int_flag_pkg::*;
(
  input  flag_op_e op,
  input  logic     oe,
  input  logic     carry_top,
  input  logic     carry_next,
  input  logic     wide_ovf,
  input  logic     sra_neg,
  input  logic     sra_lost,
  input  flags_t   mt_flags,
  input  flags_t   cur,
  output flags_t   nxt
);

  logic ov_set;
  logic signed_ovf;

  assign signed_ovf = carry_top ^ carry_next;

  always_comb begin
    nxt    = cur;
    ov_set = 1'b0;
    unique case (op)
      OP_ADDSUB: begin
        if (oe) begin
          nxt.ov = signed_ovf;
          ov_set = signed_ovf;
        end
      end
      OP_CARRY: begin
        nxt.ca = carry_top;
        if (oe) begin
          nxt.ov = signed_ovf;
          ov_set = signed_ovf;
        end
      end
      OP_MULLO, OP_DIVW: begin
        if (oe) begin
          nxt.ov = wide_ovf;
          ov_set = wide_ovf;
        end
      end
      OP_SRAW:    nxt.ca = sra_neg & sra_lost;
      OP_MOVE_TO: nxt = mt_flags;
      OP_MOVE_CR: nxt = '0;
      default:    nxt = cur;
    endcase
    if (ov_set) nxt.so = 1'b1;
  end

endmodule

// File: rtl/int_cr0_form.sv
module int_cr0_form
  import int_flag_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] result,
  input  logic            move_cr,
  input  flags_t          cur,
  input  logic            so_new,
  output logic [3:0]      field
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = result[XLEN-1];
  assign is_zero = (result == '0);

  always_comb begin
    if (move_cr) field = {cur.so, cur.ov, cur.ca, 1'b0};
    else         field = {is_neg, ~is_neg & ~is_zero, is_zero, so_new};
  end

endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit
  import int_flag_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic            oe,
  input  logic            rec,
  input  logic [XLEN-1:0] result,
  input  logic            carry_top,
  input  logic            carry_next,
  input  logic            wide_ovf,
  input  logic            sra_neg,
  input  logic            sra_lost,
  input  logic [XLEN-1:0] mt_data,
  output logic [XLEN-1:0] xer_o,
  output logic [3:0]      cr0_o
);

  localparam int RSV_W = XLEN - FLAG_W - CNT_W;

  flag_op_e          op_e;
  flags_t            flags_q, flags_d, mt_flags;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        cr0_q, cr0_d;
  logic              is_move_to, is_move_cr;

  assign op_e       = flag_op_e'(op);
  assign is_move_to = (op_e == OP_MOVE_TO);
  assign is_move_cr = (op_e == OP_MOVE_CR);
  assign mt_flags   = flags_t'(mt_data[XLEN-1 -: FLAG_W]);

  int_flag_next u_next (
    .op         (op_e),
    .oe         (oe),
    .carry_top  (carry_top),
    .carry_next (carry_next),
    .wide_ovf   (wide_ovf),
    .sra_neg    (sra_neg),
    .sra_lost   (sra_lost),
    .mt_flags   (mt_flags),
    .cur        (flags_q),
    .nxt        (flags_d)
  );

  int_cr0_form #(.XLEN(XLEN)) u_cr0 (
    .result  (result),
    .move_cr (is_move_cr),
    .cur     (flags_q),
    .so_new  (flags_d.so),
    .field   (cr0_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cnt_q   <= '0;
      cr0_q   <= '0;
    end else if (in_valid) begin
      flags_q <= flags_d;
      if (is_move_to)        cnt_q <= mt_data[CNT_W-1:0];
      if (rec || is_move_cr) cr0_q <= cr0_d;
    end
  end

  assign xer_o = {flags_q, {RSV_W{1'b0}}, cnt_q};
  assign cr0_o = cr0_q;

  // R4: sticky summary overflow survives every op except the two moves
  a_r4_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xer_o[XLEN-1] && !(in_valid && (is_move_to || is_move_cr))) |=> xer_o[XLEN-1]);

  // R8: compare leaves all flags as they were
  a_r8_cmp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> (xer_o[XLEN-1 -: 3] == $past(xer_o[XLEN-1 -: 3])));

  // R10: move to condition field clears the flags
  a_r10_move_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> (xer_o[XLEN-1 -: 3] == 3'b000));

  // R5: move-to loads flags literally from the data word
  a_r5_move_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7) |=> (xer_o[XLEN-1 -: 3] == $past(mt_data[XLEN-1 -: 3])));

  // R7: shift of a non-negative operand clears carry
  a_r7_sra_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd5 && !sra_neg) |=> !xer_o[XLEN-3]);

  // R9: a recorded result has exactly one of LT/GT/EQ set
  a_r9_cr0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rec && op != 4'd8) |=> ($countones(cr0_o[3:1]) == 1));

  // R11: nothing moves without the valid strobe
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(xer_o) && $stable(cr0_o)));

endmodule

// File: tb/int_flag_unit_tb.sv
module int_flag_unit_tb;

  typedef struct packed {
    logic [3:0]  op;
    logic        oe;
    logic        rec;
    logic [31:0] res;
    logic        ct;
    logic        cn;
    logic        wide;
    logic        neg;
    logic        lost;
    logic [31:0] mt;
    logic [2:0]  exp_fl;
    logic [3:0]  exp_cr;
  } vec_t;

  function automatic vec_t mk(logic [3:0] op, logic oe, logic rec, logic [31:0] res,
                              logic ct, logic cn, logic wide, logic neg, logic lost,
                              logic [31:0] mt, logic [2:0] fl, logic [3:0] cr);
    vec_t v;
    v.op = op; v.oe = oe; v.rec = rec; v.res = res; v.ct = ct; v.cn = cn;
    v.wide = wide; v.neg = neg; v.lost = lost; v.mt = mt; v.exp_fl = fl; v.exp_cr = cr;
    return v;
  endfunction

  localparam int NV = 14;
  // flags {SO,OV,CA}; cr0 {LT,GT,EQ,SO}
  localparam vec_t TBL [NV] = '{
    mk(4'd1, 1, 1, 32'h8000_0000, 0, 1, 0, 0, 0, 32'h0, 3'b110, 4'b1001), // R2 R4 R9
    mk(4'd1, 1, 0, 32'h0,         1, 1, 0, 0, 0, 32'h0, 3'b100, 4'b1001), // R2 R4
    mk(4'd6, 1, 1, 32'h0,         1, 0, 1, 1, 1, 32'h0, 3'b100, 4'b0011), // R8 R9
    mk(4'd2, 0, 1, 32'h5,         1, 0, 0, 0, 0, 32'h0, 3'b101, 4'b0101), // R6 R9
    mk(4'd5, 0, 0, 32'h0,         0, 0, 0, 1, 0, 32'h0, 3'b100, 4'b0101), // R7
    mk(4'd5, 0, 0, 32'h0,         0, 0, 0, 1, 1, 32'h0, 3'b101, 4'b0101), // R7
    mk(4'd5, 0, 0, 32'h0,         0, 0, 0, 0, 1, 32'h0, 3'b100, 4'b0101), // R7
    mk(4'd8, 0, 0, 32'h0,         0, 0, 0, 0, 0, 32'h0, 3'b000, 4'b1000), // R10
    mk(4'd3, 1, 1, 32'h1234,      0, 0, 1, 0, 0, 32'h0, 3'b110, 4'b0101), // R3 R4 R9
    mk(4'd7, 0, 0, 32'h0,         0, 0, 0, 0, 0, 32'h4000_007F, 3'b010, 4'b0101), // R5
    mk(4'd4, 0, 0, 32'h0,         0, 0, 1, 0, 0, 32'h0, 3'b010, 4'b0101), // R3
    mk(4'd0, 1, 1, 32'hFFFF_FFFF, 1, 0, 1, 1, 1, 32'h0, 3'b010, 4'b1000), // R8 R9
    mk(4'd4, 1, 0, 32'h0,         0, 0, 0, 0, 0, 32'h0, 3'b000, 4'b1000), // R3
    mk(4'd7, 0, 0, 32'h0,         0, 0, 0, 0, 0, 32'hFFFF_FFFF, 3'b111, 4'b1000)  // R5 R1
  };
  string tags [NV] = '{"R2","R2","R8","R6","R7","R7","R7","R10","R3","R5","R3","R8","R3","R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        oe = 1'b0, rec = 1'b0;
  logic [31:0] result = '0, mt_data = '0;
  logic        carry_top = 1'b0, carry_next = 1'b0, wide_ovf = 1'b0;
  logic        sra_neg = 1'b0, sra_lost = 1'b0;
  logic [31:0] xer_o;
  logic [3:0]  cr0_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  int_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .oe(oe), .rec(rec),
    .result(result), .carry_top(carry_top), .carry_next(carry_next),
    .wide_ovf(wide_ovf), .sra_neg(sra_neg), .sra_lost(sra_lost),
    .mt_data(mt_data), .xer_o(xer_o), .cr0_o(cr0_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic vld);
    @(negedge clk);
    in_valid = vld; op = v.op; oe = v.oe; rec = v.rec; result = v.res;
    carry_top = v.ct; carry_next = v.cn; wide_ovf = v.wide;
    sra_neg = v.neg; sra_lost = v.lost; mt_data = v.mt;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", xer_o, 32'h0);
    check("R12", {28'h0, cr0_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      check(tags[i], {29'h0, xer_o[31:29]}, {29'h0, TBL[i].exp_fl});
      check(tags[i], {28'h0, cr0_o}, {28'h0, TBL[i].exp_cr});
      check("R1", {10'h0, xer_o[28:7]}, 32'h0);
    end
    // R1 and R5: full word after literal all-ones move
    check("R1", xer_o, 32'hE000_007F);

    // R11: invalid op must not move anything
    drive(mk(4'd8, 1, 1, 32'h0, 1, 0, 1, 1, 1, 32'h0, 3'b0, 4'b0), 1'b0);
    check("R11", xer_o, 32'hE000_007F);
    check("R11", {28'h0, cr0_o}, 32'h8);

    // R1: count loaded by move-to, kept by arithmetic and by op 8 (R10)
    drive(mk(4'd7, 0, 0, 32'h0, 0, 0, 0, 0, 0, 32'h0000_0015, 3'b0, 4'b0), 1'b1);
    check("R1", xer_o, 32'h0000_0015);
    drive(mk(4'd2, 1, 0, 32'h0, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 3'b0, 4'b0), 1'b1);
    check("R6", xer_o, 32'hE000_0015);
    drive(mk(4'd8, 0, 1, 32'h0, 0, 0, 0, 0, 0, 32'h0, 3'b0, 4'b0), 1'b1);
    check("R10", xer_o, 32'h0000_0015);
    check("R10", {28'h0, cr0_o}, 32'hE);

    // R2: plain add (oe low) leaves overflow alone
    drive(mk(4'd1, 0, 1, 32'h0, 0, 1, 0, 0, 0, 32'h0, 3'b0, 4'b0), 1'b1);
    check("R2", {29'h0, xer_o[31:29]}, 32'h0);
    check("R9", {28'h0, cr0_o}, 32'h2);

    // R12: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", xer_o, 32'h0);
    check("R12", {28'h0, cr0_o}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule